// File: doc/BRIEF.md
# MII transmit frame encapsulator

This block sits between a MAC-side byte source and the transmit nibble bus of an MII PHY. The source offers payload bytes with a valid/ready handshake. Each byte carries a flag that marks the final byte of the frame and a flag that requests a line error for that byte. For every frame the block first sends the synchronisation pattern: fifteen nibbles of 0x5 followed by the delimiter nibble 0xD. That is seven 0x55 bytes and then the byte 0xD5, each byte sent low nibble first. It then sends each payload byte as two nibbles, bits 3:0 before bits 7:4. Transmit enable stays high from the first preamble nibble to the last data nibble. Dropping it is the only end-of-frame mark.

After each frame the block keeps the line quiet for a configurable gap, counted in nibble clocks. It runs on the PHY transmit clock and has no rate-dependent logic, so the same netlist serves both data rates. A frame starts when a byte is offered while the block is idle. If the source has no byte ready when the next one is due, the frame is aborted: two nibbles are sent with the error output raised, and then the frame ends.

Top module: `mii_tx_encap`

## Requirements
- R1: While reset is high and on the cycle after it, tx_en, tx_er and txd are all 0 and in_ready is 0.
- R2: A frame starts with 16 nibbles with tx_en high and tx_er low: fifteen 0x5, then 0xD. tx_en rises on the first clock edge at which in_valid is seen high while the block is idle.
- R3: An accepted byte appears as two consecutive nibbles, first in_data[3:0] and then in_data[7:4]. The nibbles of consecutive accepted bytes follow each other with no break, and tx_en stays high.
- R4: After the high nibble of a byte accepted with in_last = 1, tx_en is 0 on the next cycle.
- R5: in_ready is high only on the cycle before a low-nibble slot: the last delimiter nibble, or a high nibble of a byte without in_last. It is never high on two cycles in a row, so at most one byte is taken every two clocks.
- R6: Both nibbles of a byte accepted with in_err = 1 carry tx_er = 1. Preamble nibbles and nibbles of bytes with in_err = 0 carry tx_er = 0.
- R7: If in_ready is high while in_valid is low, the next two nibbles have txd = 0 with tx_en = 1 and tx_er = 1, and then tx_en drops.
- R8: tx_en stays low for at least IFG cycles between frames. When the next byte is already waiting, the low period is exactly IFG cycles.
- R9: Whenever tx_en is 0, txd is 0 and tx_er is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY transmit clock, one nibble per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte from the MAC side |
| in_valid | input | 1 | in_data, in_last and in_err are offered |
| in_last | input | 1 | Offered byte is the final byte of the frame |
| in_err | input | 1 | Offered byte is to be sent with the line error raised |
| in_ready | output | 1 | Block takes the offered byte at this clock edge |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | Transmit enable, high for the whole frame |
| tx_er | output | 1 | Transmit error request to the PHY |

## Verification
The stimulus is random frame traffic of 1 to 20 bytes. It has sparse per-byte error flags, occasional underruns at a random byte, and idle spacing that is either zero or random. Zero spacing separates a gap that is merely long enough from one that is exactly IFG. Directed frames cover a single-byte frame, the start latency from idle, an underrun at the second byte and a back-to-back pair. Each transmitted nibble is compared with a sequence the bench builds from the bytes it handed over. That comparison separates wrong nibble order, wrong delimiter placement, a lost or duplicated byte, an error flag on the wrong nibble and a frame that ends one nibble early or late.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LO,
    ST_HI,
    ST_ABT,
    ST_GAP
  } tx_state_t;

  localparam logic [3:0] SYNC_NIB  = 4'h5;
  localparam logic [3:0] DELIM_NIB = 4'hD;
  localparam logic [3:0] ZERO_NIB  = 4'h0;
endpackage

// File: rtl/mii_tx_gap.sv
module mii_tx_gap #(
  parameter int IFG = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic in_gap,
  output logic gap_last
);
  localparam int GW = (IFG > 1) ? $clog2(IFG) : 1;

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !in_gap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + GW'(1);
    end
  end

  assign gap_last = in_gap && (cnt == GW'(IFG - 1));
endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_err,
  input  logic       gap_last,
  output logic       in_ready,
  output logic       in_gap,
  output logic       nx_en,
  output logic       nx_er,
  output logic [3:0] nx_d
);
  localparam int PRE_NIBBLES = 2 * (PRE_BYTES + 1);
  localparam int PW = $clog2(PRE_NIBBLES);
  localparam logic [PW-1:0] LAST_PRE = PW'(PRE_NIBBLES - 1);

  tx_state_t     state, st_n;
  logic [PW-1:0] cnt, cnt_n;
  logic [3:0]    hold_hi;
  logic          hold_er;
  logic          hold_last;
  logic          take;

  assign in_ready = ((state == ST_PRE) && (cnt == LAST_PRE)) ||
                    ((state == ST_HI) && !hold_last);
  assign in_gap   = (state == ST_GAP);

  always_comb begin
    st_n  = state;
    cnt_n = cnt;
    take  = 1'b0;
    nx_en = 1'b0;
    nx_er = 1'b0;
    nx_d  = ZERO_NIB;
    case (state)
      ST_IDLE: begin
        if (in_valid) begin
          st_n  = ST_PRE;
          cnt_n = '0;
          nx_en = 1'b1;
          nx_d  = SYNC_NIB;
        end
      end
      ST_PRE: begin
        if (cnt != LAST_PRE) begin
          cnt_n = cnt + PW'(1);
          nx_en = 1'b1;
          nx_d  = ((cnt + PW'(1)) == LAST_PRE) ? DELIM_NIB : SYNC_NIB;
        end
      end
      ST_LO: begin
        st_n  = ST_HI;
        nx_en = 1'b1;
        nx_er = hold_er;
        nx_d  = hold_hi;
      end
      ST_HI: begin
        if (hold_last) begin
          st_n = ST_GAP;
        end
      end
      ST_ABT: begin
        if (cnt == '0) begin
          cnt_n = PW'(1);
          nx_en = 1'b1;
          nx_er = 1'b1;
        end else begin
          st_n = ST_GAP;
        end
      end
      ST_GAP: begin
        if (gap_last) begin
          if (in_valid) begin
            st_n  = ST_PRE;
            cnt_n = '0;
            nx_en = 1'b1;
            nx_d  = SYNC_NIB;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (in_ready) begin
      if (in_valid) begin
        take  = 1'b1;
        st_n  = ST_LO;
        nx_en = 1'b1;
        nx_er = in_err;
        nx_d  = in_data[3:0];
      end else begin
        st_n  = ST_ABT;
        cnt_n = '0;
        nx_en = 1'b1;
        nx_er = 1'b1;
        nx_d  = ZERO_NIB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hold_hi   <= '0;
      hold_er   <= 1'b0;
      hold_last <= 1'b0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      if (take) begin
        hold_hi   <= in_data[7:4];
        hold_er   <= in_err;
        hold_last <= in_last;
      end
    end
  end
endmodule

// File: rtl/mii_tx_out.sv
module mii_tx_out #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nx_en,
  input  logic          nx_er,
  input  logic [NW-1:0] nx_d,
  output logic          tx_en,
  output logic          tx_er,
  output logic [NW-1:0] txd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      tx_er <= 1'b0;
      txd   <= '0;
    end else begin
      tx_en <= nx_en;
      tx_er <= nx_en & nx_er;
      txd   <= nx_en ? nx_d : '0;
    end
  end
endmodule

// File: rtl/mii_tx_encap.sv
module mii_tx_encap #(
  parameter int IFG       = 24,
  parameter int PRE_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_err,
  output logic       in_ready,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  logic       in_gap;
  logic       gap_last;
  logic       nx_en;
  logic       nx_er;
  logic [3:0] nx_d;

  mii_tx_seq #(.PRE_BYTES(PRE_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_err   (in_err),
    .gap_last (gap_last),
    .in_ready (in_ready),
    .in_gap   (in_gap),
    .nx_en    (nx_en),
    .nx_er    (nx_er),
    .nx_d     (nx_d)
  );

  mii_tx_gap #(.IFG(IFG)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .in_gap   (in_gap),
    .gap_last (gap_last)
  );

  mii_tx_out #(.NW(4)) u_out (
    .clk   (clk),
    .rst   (rst),
    .nx_en (nx_en),
    .nx_er (nx_er),
    .nx_d  (nx_d),
    .tx_en (tx_en),
    .tx_er (tx_er),
    .txd   (txd)
  );
endmodule

// File: rtl/mii_tx_encap_chk.sv
module mii_tx_encap_chk #(
  parameter int IFG = 24
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] in_data,
  input logic       in_valid,
  input logic       in_last,
  input logic       in_err,
  input logic       in_ready,
  input logic [3:0] txd,
  input logic       tx_en,
  input logic       tx_er
);
  int   low_cnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= 0;
      seen    <= 1'b0;
    end else if (tx_en) begin
      low_cnt <= 0;
      seen    <= 1'b1;
    end else if (low_cnt < IFG) begin
      low_cnt <= low_cnt + 1;
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tx_en && !tx_er && txd == 4'h0 && !in_ready));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (txd == 4'h0 && !tx_er));

  a_r2_first_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (txd == 4'h5 && !tx_er));

  a_r5_ready_spaced: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  a_r5_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_en);

  a_r3_low_first: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (tx_en && txd == $past(in_data[3:0])));

  a_r3_high_second: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> ##1 (tx_en && txd == $past(in_data[7:4], 2)));

  a_r6_err_low: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (tx_er == $past(in_err)));

  a_r4_last_end: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && in_last) |=> ##2 !tx_en);

  a_r7_abort_nib: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (tx_en && tx_er && txd == 4'h0));

  a_r7_abort_end: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ##2 !tx_en);

  a_r8_gap_len: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && seen) |-> (low_cnt >= IFG));
endmodule

bind mii_tx_encap mii_tx_encap_chk #(.IFG(IFG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_data  (in_data),
  .in_valid (in_valid),
  .in_last  (in_last),
  .in_err   (in_err),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_en    (tx_en),
  .tx_er    (tx_er)
);

// File: tb/mii_tx_encap_tb.sv
module mii_tx_encap_tb;
  localparam int IFG = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_err = 1'b0;
  logic       in_ready;
  logic [3:0] txd;
  logic       tx_en;
  logic       tx_er;

  always #2 clk = ~clk;

  mii_tx_encap #(.IFG(IFG)) u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  // entry: [6] end marker, [5] abort nibble, [4] tx_er, [3:0] txd
  logic [6:0] expq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input bit e, input bit ab, input bit er, input logic [3:0] d);
    return {e, ab, er, d};
  endfunction

  // monitor
  logic       prev_en = 0;
  logic       prev_rdy = 0;
  bit         seen = 0;
  int         low_run = 0;
  int         last_gap = 0;
  int         nib_idx = 0;
  logic [6:0] ent;
  string      tag;

  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_en) begin
        if (!prev_en) begin
          nib_idx = 0;
          if (seen) chk(low_run >= IFG, "R8 gap too short", low_run, IFG);
          last_gap = low_run;
          seen = 1;
        end
        ent = (expq.size() > 0) ? expq.pop_front() : 7'h40;
        if (ent[6]) tag = "R4 frame too long";
        else if (ent[5]) tag = "R7 abort nibble";
        else if (ent[4] || tx_er) tag = "R6 error nibble";
        else if (nib_idx < 16) tag = "R2 preamble nibble";
        else tag = "R3 data nibble";
        chk(!ent[6] && {tx_er, txd} == ent[4:0], tag, int'({tx_er, txd}), int'(ent[4:0]));
        nib_idx++;
        low_run = 0;
      end else begin
        chk(txd == 4'h0 && !tx_er, "R9 idle bus", int'({tx_er, txd}), 0);
        if (prev_en) begin
          ent = (expq.size() > 0) ? expq.pop_front() : 7'h00;
          chk(ent[6], "R4 frame end", int'(ent), 64);
        end
        low_run++;
      end
      if (in_ready) chk(tx_en && !prev_rdy, "R5 ready spacing", int'({tx_en, prev_rdy}), 2);
      prev_en = tx_en;
      prev_rdy = in_ready;
    end
  end

  // called at a negedge, returns at a negedge
  task automatic send_frame(input int len, input int cut, input bit chk_lat, input int err_div);
    logic [7:0] b;
    bit e;
    for (int k = 0; k < 15; k++) expq.push_back(mk(0, 0, 0, 4'h5));
    expq.push_back(mk(0, 0, 0, 4'hD));
    for (int i = 0; i < len; i++) begin
      if (i == cut) begin
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        expq.push_back(mk(0, 1, 1, 4'h0));
        expq.push_back(mk(0, 1, 1, 4'h0));
        expq.push_back(mk(1, 0, 0, 4'h0));
        @(negedge clk);
        break;
      end
      b = 8'($urandom);
      e = (err_div > 0) && ($urandom % err_div == 0);
      in_data = b;
      in_err = e;
      in_last = (i == len - 1);
      in_valid = 1'b1;
      if (i == 0 && chk_lat) begin
        @(negedge clk);
        chk(tx_en && txd == 4'h5, "R2 start latency", int'({tx_en, txd}), 21);
      end
      while (!in_ready) @(negedge clk);
      expq.push_back(mk(0, 0, e, b[3:0]));
      expq.push_back(mk(0, 0, e, b[7:4]));
      if (i == len - 1) expq.push_back(mk(1, 0, 0, 4'h0));
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    in_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (4) @(negedge clk);
    chk(!tx_en && !tx_er && txd == 4'h0 && !in_ready, "R1 reset state",
        int'({in_ready, tx_en, tx_er, txd}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && !tx_er && txd == 4'h0 && !in_ready, "R1 after reset",
        int'({in_ready, tx_en, tx_er, txd}), 0);
    mon_on = 1;
    repeat (3) @(negedge clk);

    // directed: single-byte frame with start latency check
    send_frame(1, -1, 1, 0);
    repeat (40) @(negedge clk);
    // directed: every byte flagged with an error
    send_frame(3, -1, 1, 1);
    repeat (40) @(negedge clk);
    // directed: underrun at the second byte
    send_frame(5, 1, 1, 0);
    // directed: back-to-back pair, gap must be exactly IFG
    send_frame(4, -1, 0, 0);
    send_frame(2, -1, 0, 0);
    chk(last_gap == IFG, "R8 exact gap", last_gap, IFG);
    repeat (40) @(negedge clk);

    for (int f = 0; f < 40; f++) begin
      int len;
      int cut;
      int idle;
      len = 1 + int'($urandom % 20);
      cut = (len > 1 && ($urandom % 6 == 0)) ? 1 + int'($urandom % (len - 1)) : -1;
      idle = ($urandom % 3 == 0) ? 0 : int'($urandom % 30);
      send_frame(len, cut, 0, 8);
      repeat (idle) @(negedge clk);
    end

    repeat (80) @(negedge clk);
    chk(expq.size() == 0, "R4 all frames ended", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule